// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the hardware half of taking an interrupt. When an accept strobe arrives with an interrupt number, it waits until the instruction in flight has retired. At that moment it copies the eight registers that make up the saved frame. It then pushes them one word at a time onto a descending stack through a single-beat memory port that uses valid/ready. After the last push it reads the handler address from the vector table.

When the vector word arrives, the block loads it as the new program counter. In the same cycle it forms the special return value for the link register, records the interrupt number in the status output and reports the final stack pointer. A one-cycle done pulse tells the core that it can start fetching from the handler. Exception return, floating-point state and nested entry are left to other logic.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done` and `mem_valid` are low, and `pc_out`, `lr_out`, `sp_out` and `irq_status` are zero.
- R2: After an accept, no memory request is made until `insn_done` has been seen high. Every cycle from the accept up to and including the cycle in which `insn_done` is high has `mem_valid` low.
- R3: Exactly eight writes are made. In order they carry PSR, return PC, LR, R12, R3, R2, R1 and R0, so R0 is the last word written.
- R4: Each written value is the one present on its register input in the cycle when `insn_done` was high. Later changes on those inputs have no effect on the written values.
- R5: Write n (n = 1..8) goes to address `sp_in - 4*n`, using the `sp_in` sampled with `insn_done`. After the sequence, `sp_out` equals that `sp_in` minus 32.
- R6: A request holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` unchanged until it is accepted with `mem_ready`. Each beat completes in the cycle in which `mem_valid` and `mem_ready` are both high.
- R7: After the eighth write is accepted, one read (`mem_write` low) is issued at address `VEC_BASE + 4*irq_num`. `VEC_BASE` defaults to 0.
- R8: The read data is loaded into `pc_out`. `lr_out` takes the value with bits [31:4] all ones and bits [3:0] equal to the `irq_code` latched at accept. `irq_status` takes the accepted interrupt number.
- R9: `done` is high for exactly one cycle, in the cycle after the vector read is accepted. `busy` is low in the next cycle.
- R10: An accept strobe that arrives while `busy` is high has no effect. It does not change the interrupt number, the addresses or the outputs, and it does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Interrupt accept strobe |
| irq_num | input | NUM_W | Number of the interrupt being accepted |
| irq_code | input | 4 | Exception-type code for the low bits of the return LR |
| insn_done | input | 1 | Instruction in progress has retired |
| gpr_r0 | input | DATA_W | Register R0 |
| gpr_r1 | input | DATA_W | Register R1 |
| gpr_r2 | input | DATA_W | Register R2 |
| gpr_r3 | input | DATA_W | Register R3 |
| gpr_r12 | input | DATA_W | Register R12 |
| gpr_lr | input | DATA_W | Current link register |
| gpr_pc_next | input | DATA_W | Address of the next instruction to resume at |
| gpr_psr | input | DATA_W | Program status register |
| sp_in | input | ADDR_W | Stack pointer before entry |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid while ready is high on a read |
| pc_out | output | DATA_W | Handler address loaded from the vector table |
| lr_out | output | DATA_W | Return link value |
| sp_out | output | ADDR_W | Stack pointer after stacking |
| irq_status | output | NUM_W | Active interrupt number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a beat that is stalled, or a second accept strobe that arrives, while the captured register inputs are being changed under the sequencer. In that situation, a wrong snapshot, a dropped beat or a restarted sequence would all still look plausible. The stimulus therefore draws `mem_ready` from a seeded random source at a per-run acceptance rate, including runs with very long stalls. It scrambles every register input in the cycle after retirement. It also fires extra accept strobes with different numbers both in the retire-wait window and during stacking. Directed runs cover interrupt number zero and the largest number, zero retire delay, and a memory that is always ready.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int BEAT_W      = $clog2(FRAME_WORDS);
  localparam int CODE_W      = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PUSH,
    ST_VEC,
    ST_DONE
  } seq_state_e;

  // Slot index in push order: PSR is pushed first, R0 last.
  localparam int SLOT_PSR = 0;
  localparam int SLOT_PC  = 1;
  localparam int SLOT_LR  = 2;
  localparam int SLOT_R12 = 3;
  localparam int SLOT_R3  = 4;
  localparam int SLOT_R2  = 5;
  localparam int SLOT_R1  = 6;
  localparam int SLOT_R0  = 7;
endpackage

// File: rtl/exc_frame_store.sv
module exc_frame_store
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_r0,
  input  logic [DATA_W-1:0] in_r1,
  input  logic [DATA_W-1:0] in_r2,
  input  logic [DATA_W-1:0] in_r3,
  input  logic [DATA_W-1:0] in_r12,
  input  logic [DATA_W-1:0] in_lr,
  input  logic [DATA_W-1:0] in_pc,
  input  logic [DATA_W-1:0] in_psr,
  input  logic [BEAT_W-1:0] beat,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] slot_d [FRAME_WORDS];
  logic [DATA_W-1:0] slot_q [FRAME_WORDS];

  always_comb begin
    slot_d[SLOT_PSR] = in_psr;
    slot_d[SLOT_PC]  = in_pc;
    slot_d[SLOT_LR]  = in_lr;
    slot_d[SLOT_R12] = in_r12;
    slot_d[SLOT_R3]  = in_r3;
    slot_d[SLOT_R2]  = in_r2;
    slot_d[SLOT_R1]  = in_r1;
    slot_d[SLOT_R0]  = in_r0;
  end

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (load) begin
        slot_q[g] <= slot_d[g];
      end
    end
  end

  assign word = slot_q[beat];
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen #(
  parameter int                  ADDR_W   = 32,
  parameter int                  NUM_W    = 6,
  parameter logic [ADDR_W-1:0]   VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_sp,
  input  logic              step,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] sp_cur,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] sp_d;
  logic [ADDR_W-1:0] sp_q;
  logic              sp_en;

  always_comb begin
    sp_en = load_sp | step;
    sp_d  = sp_q;
    if (load_sp) begin
      sp_d = sp_in - WORD_BYTES;
    end else if (step) begin
      sp_d = sp_q - WORD_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp_cur   = sp_q;
  assign vec_addr = VEC_BASE + (ADDR_W'(num) << 2);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int NUM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              insn_done,
  input  logic              mem_ready,
  output logic              busy,
  output logic              load_frame,
  output logic              load_sp,
  output logic              step,
  output logic [BEAT_W-1:0] beat,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              capture,
  output logic              done,
  output logic [NUM_W-1:0]  num_q,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [NUM_W-1:0]  num_d;
  logic [CODE_W-1:0] code_d;
  logic              tag_en;

  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    num_d      = num_q;
    code_d     = code_q;
    tag_en     = 1'b0;
    load_frame = 1'b0;
    load_sp    = 1'b0;
    step       = 1'b0;
    capture    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (irq_take) begin
          tag_en  = 1'b1;
          num_d   = irq_num;
          code_d  = irq_code;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (insn_done) begin
          load_frame = 1'b1;
          load_sp    = 1'b1;
          beat_d     = '0;
          state_d    = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (mem_ready) begin
          if (beat_q == LAST_BEAT) begin
            state_d = ST_VEC;
          end else begin
            beat_d = beat_q + 1'b1;
            step   = 1'b1;
          end
        end
      end
      ST_VEC: begin
        if (mem_ready) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      code_q <= '0;
    end else if (tag_en) begin
      num_q  <= num_d;
      code_q <= code_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_valid = (state_q == ST_PUSH) || (state_q == ST_VEC);
  assign mem_write = (state_q == ST_PUSH);
  assign done      = (state_q == ST_DONE);
  assign beat      = beat_q;

  // R10
  accept_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_take) |=> $stable(num_q) && $stable(code_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_take) |=> !mem_valid);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter int                NUM_W    = 6,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic [NUM_W-1:0]  irq_num,
  input  logic [3:0]        irq_code,
  input  logic              insn_done,
  input  logic [DATA_W-1:0] gpr_r0,
  input  logic [DATA_W-1:0] gpr_r1,
  input  logic [DATA_W-1:0] gpr_r2,
  input  logic [DATA_W-1:0] gpr_r3,
  input  logic [DATA_W-1:0] gpr_r12,
  input  logic [DATA_W-1:0] gpr_lr,
  input  logic [DATA_W-1:0] gpr_pc_next,
  input  logic [DATA_W-1:0] gpr_psr,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] lr_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [NUM_W-1:0]  irq_status,
  output logic              busy,
  output logic              done
);
  localparam logic [DATA_W-CODE_W-1:0] LR_HIGH = '1;

  logic              load_frame, load_sp, step, capture;
  logic [BEAT_W-1:0] beat;
  logic [NUM_W-1:0]  num_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] frame_word;
  logic [ADDR_W-1:0] sp_cur, vec_addr;

  logic [DATA_W-1:0] pc_d, lr_d;
  logic [ADDR_W-1:0] sp_d;
  logic [NUM_W-1:0]  stat_d;

  exc_entry_ctrl #(.NUM_W(NUM_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_take   (irq_take),
    .irq_num    (irq_num),
    .irq_code   (irq_code),
    .insn_done  (insn_done),
    .mem_ready  (mem_ready),
    .busy       (busy),
    .load_frame (load_frame),
    .load_sp    (load_sp),
    .step       (step),
    .beat       (beat),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .capture    (capture),
    .done       (done),
    .num_q      (num_q),
    .code_q     (code_q)
  );

  exc_frame_store #(.DATA_W(DATA_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_frame),
    .in_r0  (gpr_r0),
    .in_r1  (gpr_r1),
    .in_r2  (gpr_r2),
    .in_r3  (gpr_r3),
    .in_r12 (gpr_r12),
    .in_lr  (gpr_lr),
    .in_pc  (gpr_pc_next),
    .in_psr (gpr_psr),
    .beat   (beat),
    .word   (frame_word)
  );

  exc_addr_gen #(
    .ADDR_W   (ADDR_W),
    .NUM_W    (NUM_W),
    .VEC_BASE (VEC_BASE)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_sp  (load_sp),
    .step     (step),
    .sp_in    (sp_in),
    .num      (num_q),
    .sp_cur   (sp_cur),
    .vec_addr (vec_addr)
  );

  assign mem_addr  = mem_write ? sp_cur : vec_addr;
  assign mem_wdata = mem_write ? frame_word : '0;

  always_comb begin
    pc_d   = mem_rdata;
    lr_d   = {LR_HIGH, code_q};
    sp_d   = sp_cur;
    stat_d = num_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out     <= '0;
      lr_out     <= '0;
      sp_out     <= '0;
      irq_status <= '0;
    end else if (capture) begin
      pc_out     <= pc_d;
      lr_out     <= lr_d;
      sp_out     <= sp_d;
      irq_status <= stat_d;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) &&
      $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_ready) |=>
      (!mem_write || (mem_addr == $past(mem_addr) - ADDR_W'(4))));

  // R8
  lr_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lr_out[DATA_W-1:CODE_W] == LR_HIGH));
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  localparam int NUM_W = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_take;
  logic [NUM_W-1:0] irq_num;
  logic [3:0]  irq_code;
  logic        insn_done;
  logic [31:0] gpr_r0, gpr_r1, gpr_r2, gpr_r3, gpr_r12, gpr_lr, gpr_pc_next, gpr_psr;
  logic [31:0] sp_in;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] pc_out, lr_out, sp_out;
  logic [NUM_W-1:0] irq_status;
  logic        busy, done;

  int check_cnt = 0;
  int fail_cnt  = 0;
  int ready_pct = 75;

  logic [31:0] wr_addr [8];
  logic [31:0] wr_data [8];
  int          wr_cnt;
  logic [31:0] rd_addr;
  int          rd_cnt;
  bit          done_due;
  bit          stall_prev;
  logic [31:0] stall_addr, stall_data;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_num(irq_num),
    .irq_code(irq_code), .insn_done(insn_done),
    .gpr_r0(gpr_r0), .gpr_r1(gpr_r1), .gpr_r2(gpr_r2), .gpr_r3(gpr_r3),
    .gpr_r12(gpr_r12), .gpr_lr(gpr_lr), .gpr_pc_next(gpr_pc_next), .gpr_psr(gpr_psr),
    .sp_in(sp_in), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .lr_out(lr_out), .sp_out(sp_out),
    .irq_status(irq_status), .busy(busy), .done(done)
  );

  function automatic logic [31:0] vec_word(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    check_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: random ready, logs accepted beats.
  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    done_due = 1'b0;
    stall_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done_due) begin
        check(done === 1'b1, "R9", "done after vector read", {31'b0, done}, 32'd1);
        done_due = 1'b0;
      end
      if (stall_prev) begin
        check(mem_valid && mem_addr == stall_addr && mem_wdata == stall_data, "R6",
              "stalled request held", mem_addr, stall_addr);
      end
      mem_ready = (($urandom % 100) < ready_pct);
      mem_rdata = vec_word(mem_addr);
      #1;
      stall_prev = rst_n && mem_valid && !mem_ready;
      stall_addr = mem_addr;
      stall_data = mem_wdata;
      if (rst_n && mem_valid && mem_ready) begin
        if (mem_write) begin
          if (wr_cnt < 8) begin
            wr_addr[wr_cnt] = mem_addr;
            wr_data[wr_cnt] = mem_wdata;
          end
          wr_cnt++;
        end else begin
          check(wr_cnt == 8, "R7", "read only after eight writes", wr_cnt, 8);
          rd_addr = mem_addr;
          rd_cnt++;
          done_due = 1'b1;
        end
      end
    end
  end

  task automatic scramble_regs();
    gpr_r0 = $urandom; gpr_r1 = $urandom; gpr_r2 = $urandom; gpr_r3 = $urandom;
    gpr_r12 = $urandom; gpr_lr = $urandom; gpr_pc_next = $urandom; gpr_psr = $urandom;
    sp_in = $urandom;
  endtask

  task automatic run_seq(input logic [NUM_W-1:0] num, input logic [3:0] code,
                         input int delay);
    logic [31:0] exp_frame [8];
    logic [31:0] sp0;
    bit seen;
    wr_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    irq_take = 1'b1; irq_num = num; irq_code = code; insn_done = 1'b0;
    scramble_regs();
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      irq_take = (i == 1);
      irq_num = ~num; irq_code = ~code;
      scramble_regs();
      #2;
      check(!mem_valid, "R2", "no request before retire", {31'b0, mem_valid}, 32'd0);
    end
    @(negedge clk);
    irq_take = 1'b0;
    insn_done = 1'b1;
    scramble_regs();
    sp0 = {$urandom % 32'h0100_0000 + 32'h2000_0000} & ~32'h3;
    sp_in = sp0;
    exp_frame[0] = gpr_psr; exp_frame[1] = gpr_pc_next; exp_frame[2] = gpr_lr;
    exp_frame[3] = gpr_r12; exp_frame[4] = gpr_r3; exp_frame[5] = gpr_r2;
    exp_frame[6] = gpr_r1;  exp_frame[7] = gpr_r0;
    #2;
    check(!mem_valid, "R2", "no request in retire cycle", {31'b0, mem_valid}, 32'd0);
    @(negedge clk);
    insn_done = 1'b0;
    scramble_regs();
    irq_take = 1'b1; irq_num = num + 1'b1; irq_code = code + 4'd1;
    @(negedge clk);
    irq_take = 1'b0;
    scramble_regs();
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      #2;
      if (done) seen = 1'b1;
    end
    check(seen, "R9", "done reached", {31'b0, seen}, 32'd1);
    check(wr_cnt == 8, "R3", "write count", wr_cnt, 8);
    for (int k = 0; k < 8; k++) begin
      check(wr_addr[k] == sp0 - 32'(4 * (k + 1)), "R5", $sformatf("addr of beat %0d", k),
            wr_addr[k], sp0 - 32'(4 * (k + 1)));
      check(wr_data[k] == exp_frame[k], "R4", $sformatf("R3 order, data of beat %0d", k),
            wr_data[k], exp_frame[k]);
    end
    check(rd_cnt == 1, "R7", "one vector read", rd_cnt, 1);
    check(rd_addr == {24'b0, num, 2'b00}, "R7", "vector address", rd_addr, {24'b0, num, 2'b00});
    check(pc_out == vec_word({24'b0, num, 2'b00}), "R8", "pc_out", pc_out,
          vec_word({24'b0, num, 2'b00}));
    check(lr_out == {28'hFFFFFFF, code}, "R8", "lr_out", lr_out, {28'hFFFFFFF, code});
    check(irq_status == num, "R10", "status keeps first number", {26'b0, irq_status}, {26'b0, num});
    check(sp_out == sp0 - 32'd32, "R5", "sp_out", sp_out, sp0 - 32'd32);
    @(negedge clk);
    #2;
    check(!done && !busy, "R9", "done one cycle then idle", {30'b0, done, busy}, 32'd0);
    repeat (3) begin
      @(negedge clk);
      #2;
      check(!busy && !mem_valid, "R10", "no restart from ignored accept",
            {30'b0, busy, mem_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check_cnt++;
    fail_cnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; irq_take = 1'b0; irq_num = '0; irq_code = '0; insn_done = 1'b0;
    scramble_regs();
    wr_cnt = 0; rd_cnt = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    #2;
    check(!busy && !done && !mem_valid, "R1", "control outputs in reset",
          {29'b0, busy, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!busy && !done && !mem_valid, "R1", "control outputs after reset",
          {29'b0, busy, done, mem_valid}, 32'd0);
    check(pc_out == 0 && lr_out == 0 && sp_out == 0 && irq_status == 0, "R1",
          "result outputs zero", pc_out | lr_out | sp_out, 32'd0);

    ready_pct = 100; run_seq(6'd0, 4'h9, 0);
    ready_pct = 100; run_seq(6'd63, 4'h1, 3);
    ready_pct = 15;  run_seq(6'd20, 4'hD, 2);
    ready_pct = 50;  run_seq(6'd5, 4'h0, 5);
    for (int t = 0; t < 20; t++) begin
      ready_pct = 20 + int'($urandom % 81);
      run_seq(NUM_W'($urandom), 4'($urandom), int'($urandom % 6));
    end
    $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
    $finish;
  end
endmodule